// File: doc/BRIEF.md
# Keyed Software Watchdog Timer

This block is a periodic-service watchdog. Once enabled, a counter advances on a divided reference tick. Software must restart it by writing a two-byte key to a service port before the counter reaches its selected limit. If it does not, the block raises a one-cycle reset request, and its counter, key tracker and control settings all go back to their reset state.

The counting rate depends on three things: a clock-mode input that inserts a fast-reference pre-divider, a programmable prescaler that can be switched in or out, and a two-bit period selector. At reset the prescaler setting is taken from a mode pin. New prescaler and period settings do not take effect while the counter is running. They are applied at the next restart, or at once while the watchdog is disabled.

Top module: `key_watchdog`

## Requirements
- R1: While `rst_ni` is low, and on the first clock after it rises (the load cycle), `count_o` is 0 and `rst_req_o` is 0. No counting takes place in the load cycle, and control writes in that cycle are ignored.
- R2: While the enable field is 0, `count_o` holds its value and `rst_req_o` stays 0. A control write that sets enable starts the counter from the next clock.
- R3: A service write of 8'h55 followed by a service write of 8'hAA clears `count_o` to 0 at the clock that accepts the 8'hAA write. Any number of idle cycles may separate the two writes.
- R4: A service write of 8'hAA with no preceding 8'h55 leaves the count unchanged. So does any other byte written between the two key bytes, after which the key must start again. A repeated 8'h55 keeps the key armed.
- R5: When the limit is reached, `rst_req_o` is high for exactly one cycle and `count_o` is 0. The next cycle is a load cycle that returns enable to `ENABLE_RST`, the period selector to 0 and the prescaler bit to the mode pin.
- R6: With `fast_ref_i` = 0, each `ref_tick_i` pulse is one counter input. With `fast_ref_i` = 1, one counter input occurs per 2^`FAST_DIV_LOG2` reference ticks. With `ref_tick_i` low the count does not move.
- R7: With the prescaler bit at 1, an extra division by 2^`PRESCALE_LOG2` is applied ahead of the counter, in either clock mode.
- R8: In each load cycle the prescaler bit takes the value of `synth_mode_i` (1 means synthesized-clock mode, 0 means external-clock mode).
- R9: A period selector value s gives a timeout after 2^(`PERIOD_BASE_LOG2` + `PERIOD_STEP_LOG2`·s) counter inputs. `count_o` runs from 0 up to that value minus one.
- R10: Prescaler and period changes written while enabled take effect only at the next key restart or load cycle. Changes written while disabled take effect on the next clock.
- R11: If the 8'hAA write arrives in the same cycle as the timeout, the timeout wins and the key is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_tick_i | input | 1 | Reference clock enable tick |
| fast_ref_i | input | 1 | 1 selects fast-reference mode (pre-divider in path) |
| synth_mode_i | input | 1 | Mode pin, gives prescaler bit reset value |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_en_i | input | 1 | Enable field of control write |
| ctrl_swp_i | input | 1 | Prescaler field of control write |
| ctrl_swt_i | input | 2 | Period selector field of control write |
| svc_we_i | input | 1 | Service byte write strobe |
| svc_data_i | input | 8 | Service byte |
| rst_req_o | output | 1 | One-cycle reset request |
| count_o | output | COUNT_W | Current counter value |

## Verification
Every result of this block is registered. A service or control write sampled at a clock edge shows its effect on `count_o` at the next falling edge. A counter input that hits the limit raises `rst_req_o` one edge later, and the load cycle follows one edge after that. The bench drives inputs on falling edges and checks on falling edges, so every expected value is written as a count of rising edges since the stimulus. A behavioural model advances on the same rising edges and is compared with both outputs at every falling edge. Small divider parameters keep the longest timeout within a few thousand cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wdog_div_stage.sv
module wdog_div_stage #(
  parameter int unsigned LOG2 = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bypass_i,
  input  logic tick_i,
  output logic tick_o
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i)             cnt_q <= '0;
    else if (tick_i && !bypass_i) cnt_q <= cnt_q + LOG2'(1);
  end

  assign tick_o = bypass_i ? tick_i : (tick_i && (&cnt_q));
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
  import wdog_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic       done_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    done_o = 1'b0;
    if (we_i) begin
      if (data_i == KEY_ARM) begin
        st_d = KEY_ARMED;
      end else if (data_i == KEY_FIRE && st_q == KEY_ARMED) begin
        done_o = 1'b1;
        st_d   = KEY_IDLE;
      end else begin
        st_d = KEY_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= KEY_IDLE;
    else if (clear_i) st_q <= KEY_IDLE;
    else              st_q <= st_d;
  end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned FAST_DIV_LOG2    = 7,
  parameter int unsigned PRESCALE_LOG2    = 9,
  parameter int unsigned PERIOD_BASE_LOG2 = 9,
  parameter int unsigned PERIOD_STEP_LOG2 = 2,
  parameter bit          ENABLE_RST       = 1'b1,
  localparam int unsigned COUNT_W = PERIOD_BASE_LOG2 + 3 * PERIOD_STEP_LOG2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ref_tick_i,
  input  logic               fast_ref_i,
  input  logic               synth_mode_i,
  input  logic               ctrl_we_i,
  input  logic               ctrl_en_i,
  input  logic               ctrl_swp_i,
  input  logic [1:0]         ctrl_swt_i,
  input  logic               svc_we_i,
  input  logic [7:0]         svc_data_i,
  output logic               rst_req_o,
  output logic [COUNT_W-1:0] count_o
);
  logic               boot_q;
  logic               en_q, swp_q, act_swp_q;
  logic [1:0]         swt_q, act_swt_q;
  logic [COUNT_W-1:0] cnt_q, limit_m1;
  logic               rst_req_q;
  logic               tick_ref, tick_fast, tick_cnt;
  logic               key_done, restart, timeout, clear_all;

  // load cycle suppresses counting
  assign tick_ref = ref_tick_i & en_q & ~boot_q;

  wdog_div_stage #(.LOG2(FAST_DIV_LOG2)) i_fast_div (
    .clk_i, .rst_ni,
    .clear_i (clear_all),
    .bypass_i(~fast_ref_i),
    .tick_i  (tick_ref),
    .tick_o  (tick_fast)
  );

  wdog_div_stage #(.LOG2(PRESCALE_LOG2)) i_pre_div (
    .clk_i, .rst_ni,
    .clear_i (clear_all),
    .bypass_i(~act_swp_q),
    .tick_i  (tick_fast),
    .tick_o  (tick_cnt)
  );

  wdog_key_seq i_key (
    .clk_i, .rst_ni,
    .clear_i(timeout | boot_q),
    .we_i   (svc_we_i),
    .data_i (svc_data_i),
    .done_o (key_done)
  );

  always_comb begin
    limit_m1 = '0;
    for (int s = 0; s < 4; s++) begin
      if (act_swt_q == 2'(s))
        limit_m1 = COUNT_W'((64'd1 << (PERIOD_BASE_LOG2 + PERIOD_STEP_LOG2 * s)) - 64'd1);
    end
  end

  // >= so a limit lowered while disabled still expires
  assign timeout   = tick_cnt & (cnt_q >= limit_m1);
  assign restart   = key_done & ~timeout & ~boot_q;
  assign clear_all = timeout | restart | boot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q    <= 1'b1;
      en_q      <= ENABLE_RST;
      swp_q     <= 1'b0;
      swt_q     <= '0;
      act_swp_q <= 1'b0;
      act_swt_q <= '0;
    end else if (boot_q) begin
      boot_q    <= 1'b0;
      en_q      <= ENABLE_RST;
      swp_q     <= synth_mode_i;
      swt_q     <= '0;
      act_swp_q <= synth_mode_i;
      act_swt_q <= '0;
    end else if (timeout) begin
      boot_q    <= 1'b1;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= ctrl_en_i;
        swp_q <= ctrl_swp_i;
        swt_q <= ctrl_swt_i;
      end
      if (restart || !en_q) begin
        act_swp_q <= swp_q;
        act_swt_q <= swt_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= timeout;
      if (clear_all)     cnt_q <= '0;
      else if (tick_cnt) cnt_q <= cnt_q + COUNT_W'(1);
    end
  end

  assign rst_req_o = rst_req_q;
  assign count_o   = cnt_q;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned COUNT_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rst_req_o,
  input logic [COUNT_W-1:0] count_o,
  input logic               en_q,
  input logic               boot_q,
  input logic               restart
);
  // R5
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  // R5
  a_r5_count_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> count_o == '0);
  // R2
  a_r2_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !boot_q && !restart) |=> $stable(count_o));
  // R2
  a_r2_no_req_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !boot_q) |=> !rst_req_o);
  // R3
  a_r3_restart_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> count_o == '0);
  // R1
  a_r1_load_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_q |=> (count_o == '0 && !rst_req_o));
  // R9
  a_r9_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != '0) |-> (count_o == $past(count_o) || count_o == $past(count_o) + COUNT_W'(1)));
endmodule

bind key_watchdog wdog_checker #(.COUNT_W(COUNT_W)) i_wdog_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rst_req_o(rst_req_o),
  .count_o  (count_o),
  .en_q     (en_q),
  .boot_q   (boot_q),
  .restart  (restart)
);

// File: tb/test_key_watchdog.sv
`timescale 1ns/1ps
module test_key_watchdog;
  localparam int FDL = 2, PDL = 3, BASE = 3, STEP = 2;
  localparam int CW = BASE + 3 * STEP;
  localparam int FD = 1 << FDL, PD = 1 << PDL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_tick = 1'b1, fast = 1'b0, synth = 1'b0;
  logic cwe = 1'b0, cen = 1'b0, cswp = 1'b0;
  logic [1:0] cswt = '0;
  logic swe = 1'b0;
  logic [7:0] sdata = '0;
  logic rst_req;
  logic [CW-1:0] count;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  key_watchdog #(
    .FAST_DIV_LOG2(FDL), .PRESCALE_LOG2(PDL),
    .PERIOD_BASE_LOG2(BASE), .PERIOD_STEP_LOG2(STEP), .ENABLE_RST(1'b1)
  ) i_key_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .fast_ref_i(fast),
    .synth_mode_i(synth), .ctrl_we_i(cwe), .ctrl_en_i(cen), .ctrl_swp_i(cswp),
    .ctrl_swt_i(cswt), .svc_we_i(swe), .svc_data_i(sdata),
    .rst_req_o(rst_req), .count_o(count)
  );

  // behavioural reference model
  int m_cnt, m_fd, m_pd, m_swt, m_aswt;
  bit m_boot, m_en, m_swp, m_aswp, m_arm, m_rst;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_boot = 1; m_en = 1; m_swp = 0; m_swt = 0; m_aswp = 0; m_aswt = 0;
      m_cnt = 0; m_fd = 0; m_pd = 0; m_arm = 0; m_rst = 0;
    end else if (m_boot) begin
      m_boot = 0; m_en = 1; m_swp = synth; m_swt = 0; m_aswp = synth; m_aswt = 0;
      m_cnt = 0; m_fd = 0; m_pd = 0; m_arm = 0; m_rst = 0;
    end else begin
      bit t0, t1, t2, to, kd, o_en, o_swp;
      int o_swt, lim;
      t0 = ref_tick && m_en;
      t1 = t0;
      if (fast) begin
        t1 = t0 && (m_fd == FD - 1);
        if (t0) m_fd = (m_fd + 1) % FD;
      end
      t2 = t1;
      if (m_aswp) begin
        t2 = t1 && (m_pd == PD - 1);
        if (t1) m_pd = (m_pd + 1) % PD;
      end
      lim = 1 << (BASE + STEP * m_aswt);
      to = t2 && (m_cnt >= lim - 1);
      kd = swe && sdata == 8'hAA && m_arm;
      m_rst = to;
      if (to) begin
        m_boot = 1; m_cnt = 0; m_fd = 0; m_pd = 0; m_arm = 0;
      end else begin
        o_en = m_en; o_swp = m_swp; o_swt = m_swt;
        if (swe) m_arm = (sdata == 8'h55);
        if (kd) begin
          m_cnt = 0; m_fd = 0; m_pd = 0; m_aswp = o_swp; m_aswt = o_swt;
        end else begin
          if (t2) m_cnt++;
          if (!o_en) begin m_aswp = o_swp; m_aswt = o_swt; end
        end
        if (cwe) begin m_en = cen; m_swp = cswp; m_swt = cswt; end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R9 model count", int'(count), m_cnt);
      check("R5 model rst_req", int'(rst_req), int'(m_rst));
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl(bit e, bit p, logic [1:0] t);
    cwe = 1; cen = e; cswp = p; cswt = t;
    @(negedge clk);
    cwe = 0;
  endtask

  task automatic svc(logic [7:0] b);
    swe = 1; sdata = b;
    @(negedge clk);
    swe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count in reset", int'(count), 0);
    check("R1 req in reset", int'(rst_req), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 load cycle count", int'(count), 0);
    ctrl(1, 0, 2'd3);
    svc(8'h55);
    wait_n(3);
    svc(8'hAA);
    check("R3 restart with gap", int'(count), 0);
    wait_n(10);
    check("R6 slow rate", int'(count), 10);
    ref_tick = 0;
    wait_n(5);
    check("R6 no tick no count", int'(count), 10);
    ref_tick = 1;
    svc(8'hAA);
    check("R4 lone AA ignored", int'(count), 11);
    svc(8'h55); svc(8'h12); svc(8'hAA);
    check("R4 broken key ignored", int'(count), 14);
    svc(8'h55); svc(8'h55); wait_n(3); svc(8'hAA);
    check("R4 repeated 55 stays armed", int'(count), 0);
    ctrl(0, 0, 2'd3);
    wait_n(20);
    check("R2 held when disabled", int'(count), 1);
    check("R2 no request when disabled", int'(rst_req), 0);
    ctrl(1, 0, 2'd3);
    wait_n(4);
    check("R2 resumes when enabled", int'(count), 5);
    fast = 1;
    svc(8'h55); svc(8'hAA);
    wait_n(40);
    check("R6 fast pre-divider", int'(count), 10);
    ctrl(1, 1, 2'd3);
    wait_n(39);
    check("R10 prescale deferred", int'(count), 20);
    svc(8'h55); svc(8'hAA);
    wait_n(320);
    check("R7 prescale applied", int'(count), 10);
    fast = 0;
    ctrl(1, 0, 2'd0);
    svc(8'h55); svc(8'hAA);
    ctrl(1, 1, 2'd2);
    wait_n(6);
    check("R10 period deferred", int'(count), 7);
    check("R9 no early request", int'(rst_req), 0);
    wait_n(1);
    check("R9 timeout at 8", int'(rst_req), 1);
    check("R5 count cleared", int'(count), 0);
    wait_n(1);
    check("R5 single pulse", int'(rst_req), 0);
    wait_n(7);
    check("R5 fields reset count", int'(count), 7);
    wait_n(1);
    check("R5 fields reset timeout", int'(rst_req), 1);
    wait_n(1);
    ctrl(1, 0, 2'd1);
    svc(8'h55); svc(8'hAA);
    wait_n(31);
    check("R9 period 32 count", int'(count), 31);
    check("R9 period 32 no req", int'(rst_req), 0);
    wait_n(1);
    check("R9 period 32 timeout", int'(rst_req), 1);
    wait_n(1);
    svc(8'h55);
    wait_n(6);
    svc(8'hAA);
    check("R11 timeout beats key", int'(rst_req), 1);
    wait_n(1);
    svc(8'hAA);
    check("R11 key discarded", int'(count), 1);
    rst_n = 0; synth = 1;
    wait_n(2);
    check("R1 count in second reset", int'(count), 0);
    rst_n = 1;
    @(negedge clk);
    wait_n(32);
    check("R8 prescale from pin", int'(count), 4);
    wait_n(31);
    check("R8 count before timeout", int'(count), 7);
    wait_n(1);
    check("R8 timeout at 64", int'(rst_req), 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule